// File: doc/BRIEF.md
# Ratio-Two Synchronous Command Bridge

This bridge carries command/data word pairs in both directions between a fast logic region and a slow one. The slow clock runs at exactly half the rate of the fast clock, and both clocks come from one common source. Every flop of the bridge is clocked by the fast clock. An internal toggle produces an enable that is high on every second fast cycle, and that enabled cycle ends on the fast edge that coincides with a rising slow edge. Slow-side inputs are treated as ordinary synchronous signals, but they are only acted on in enabled cycles. Slow-side outputs only change at the end of enabled cycles.

Toward the slow side, the fast side offers a word with a valid/ready handshake. The bridge registers the command and the data together and raises a request. It holds all three outputs steady until the slow side returns an acknowledge. From the slow side, a word arrives with its own request. The bridge copies it once into a holding register, acknowledges it for exactly one slow period, and offers it to the fast side as valid until the fast side takes it.

The design has no synchronizers and no FIFO. All timing safety comes from the fixed phase relation between the two clocks.

Top module: `ratio2_cmd_bridge`

## Requirements
- R1: While `rst_n` is low, `dn_req`, `up_ack` and `rx_valid` are 0.
- R2: With `LEAD_EN`=1, the cycle in which reset is released is an enabled cycle, and enabled and disabled cycles then alternate. `tx_ready` is 1 exactly in enabled cycles with no outbound request pending. A `tx_valid` held only through a disabled cycle is not taken.
- R3: `dn_req`, `dn_cmd` and `dn_data` change only at the end of an enabled cycle, so each value stays for at least two fast cycles.
- R4: A word taken with `tx_valid`=1 and `tx_ready`=1 appears on `dn_cmd`/`dn_data` in the next cycle, with `dn_req`=1. Command and data are always shown together.
- R5: `dn_req` stays 1 until `dn_ack`=1 is seen in an enabled cycle, and drops at the end of that cycle. `tx_ready` stays 0 while `dn_req` is 1.
- R6: `dn_ack`=1 during a disabled cycle has no effect.
- R7: If `up_req`=1 in an enabled cycle while `up_ack`=0 and `rx_valid`=0, the word on `up_cmd`/`up_data` is captured. In the next cycle `rx_valid`=1 with that word, and `up_ack` is 1 for exactly two fast cycles.
- R8: A slow word that is still shown while `up_ack`=1 is not captured a second time.
- R9: `rx_valid` and the word on `rx_cmd`/`rx_data` stay unchanged until a cycle with `rx_ready`=1. `rx_valid` is 0 in the cycle after that.
- R10: While `rx_valid`=1, a pending `up_req` is not acknowledged.
- R11: `up_req`=1 present only during a disabled cycle is neither captured nor acknowledged.
- R12: Under random stalls on both sides, every word is delivered exactly once, in order, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, phase locked at twice the slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Fast side offers an outbound word |
| tx_ready | output | 1 | Bridge takes the outbound word this cycle |
| tx_cmd | input | CMD_W | Outbound command |
| tx_data | input | DATA_W | Outbound data |
| dn_req | output | 1 | Request to the slow side |
| dn_cmd | output | CMD_W | Command presented to the slow side |
| dn_data | output | DATA_W | Data presented to the slow side |
| dn_ack | input | 1 | Slow side has taken the presented word |
| up_req | input | 1 | Slow side presents an inbound word |
| up_cmd | input | CMD_W | Inbound command |
| up_data | input | DATA_W | Inbound data |
| up_ack | output | 1 | Bridge has captured the inbound word |
| rx_valid | output | 1 | Captured inbound word available to the fast side |
| rx_ready | input | 1 | Fast side takes the inbound word |
| rx_cmd | output | CMD_W | Inbound command to the fast side |
| rx_data | output | DATA_W | Inbound data to the fast side |

## Verification
The hardest cases to reach are defined at fast-cycle granularity rather than by a slow-clocked partner. One is an inbound word that stays on the pins during the second cycle of the acknowledge. Others are an acknowledge or request that is present for only a disabled cycle, and a request that waits behind a full holding register. A well-behaved partner never produces these. So the first phase drives the slow-side pins directly, cycle by cycle, from a known enable phase set by the reset release. Only after that does a slow-clocked partner model take over for the table-driven and random traffic.

// File: rtl/r2_bridge_pkg.sv
package r2_bridge_pkg;

    typedef enum logic {
        DN_IDLE = 1'b0,
        DN_BUSY = 1'b1
    } dn_state_e;

endpackage

// File: rtl/r2_phase_gen.sv
module r2_phase_gen #(
    parameter bit LEAD_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output logic en
);

    typedef struct packed {
        logic ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = ~st_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.ph ^ LEAD_EN;

    // R2: strict alternation of enabled and disabled cycles
    a_r2_en_falls: assert property (@(posedge clk) disable iff (!rst_n) en |=> !en);
    a_r2_en_rises: assert property (@(posedge clk) disable iff (!rst_n) !en |=> en);

endmodule

// File: rtl/r2_dn_path.sv
module r2_dn_path
    import r2_bridge_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [CMD_W-1:0]  tx_cmd,
    input  logic [DATA_W-1:0] tx_data,
    output logic              dn_req,
    output logic [CMD_W-1:0]  dn_cmd,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ack
);

    localparam int WORD_W = CMD_W + DATA_W;

    typedef struct packed {
        dn_state_e         state;
        logic [WORD_W-1:0] word;
    } dn_st_t;

    dn_st_t st_d, st_q;
    logic   take;

    always_comb begin
        st_d     = st_q;
        tx_ready = en && (st_q.state == DN_IDLE);
        take     = tx_ready && tx_valid;
        if (take) begin
            st_d.state = DN_BUSY;
            st_d.word  = {tx_cmd, tx_data};
        end else if (en && (st_q.state == DN_BUSY) && dn_ack) begin
            st_d.state = DN_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= DN_IDLE;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dn_req            = (st_q.state == DN_BUSY);
    assign {dn_cmd, dn_data} = st_q.word;

    // R3: slow-facing outputs only move after an enabled cycle
    a_r3_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dn_req) && $stable(dn_cmd) && $stable(dn_data)));
    // R4: the taken word is launched as one pair
    a_r4_word_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (dn_req && dn_cmd == $past(tx_cmd) && dn_data == $past(tx_data)));
    // R5 and R6: request persists until an acknowledge seen in an enabled cycle
    a_r5_req_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !(en && dn_ack)) |=> dn_req);
    a_r5_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> !tx_ready);

endmodule

// File: rtl/r2_up_path.sv
module r2_up_path #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              up_req,
    input  logic [CMD_W-1:0]  up_cmd,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ack,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [CMD_W-1:0]  rx_cmd,
    output logic [DATA_W-1:0] rx_data
);

    localparam int WORD_W = CMD_W + DATA_W;

    typedef struct packed {
        logic              ack;
        logic              full;
        logic [WORD_W-1:0] word;
    } up_st_t;

    up_st_t st_d, st_q;
    logic   take;

    always_comb begin
        st_d = st_q;
        take = en && up_req && !st_q.ack && !st_q.full;
        if (st_q.full && rx_ready) begin
            st_d.full = 1'b0;
        end
        if (en) begin
            st_d.ack = take;
        end
        if (take) begin
            st_d.full = 1'b1;
            st_d.word = {up_cmd, up_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_ack            = st_q.ack;
    assign rx_valid          = st_q.full;
    assign {rx_cmd, rx_data} = st_q.word;

    // R7: acknowledge covers one enabled window only
    a_r7_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up_ack) |=> !up_ack);
    // R8: no second capture while the acknowledge is out
    a_r8_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up_ack) |=> !$rose(rx_valid));
    // R9: offered word holds until taken
    a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_cmd) && $stable(rx_data)));
    // R10: a full holding register blocks new acknowledges
    a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> !$rose(up_ack));
    // R11: acknowledge never moves after a disabled cycle
    a_r11_ack_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(up_ack));

endmodule

// File: rtl/ratio2_cmd_bridge.sv
module ratio2_cmd_bridge #(
    parameter int CMD_W   = 8,
    parameter int DATA_W  = 32,
    parameter bit LEAD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [CMD_W-1:0]  tx_cmd,
    input  logic [DATA_W-1:0] tx_data,
    output logic              dn_req,
    output logic [CMD_W-1:0]  dn_cmd,
    output logic [DATA_W-1:0] dn_data,
    input  logic              dn_ack,
    input  logic              up_req,
    input  logic [CMD_W-1:0]  up_cmd,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ack,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [CMD_W-1:0]  rx_cmd,
    output logic [DATA_W-1:0] rx_data
);

    logic slow_en;

    r2_phase_gen #(
        .LEAD_EN (LEAD_EN)
    ) i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (slow_en)
    );

    r2_dn_path #(
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W)
    ) i_dn (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (slow_en),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_cmd   (tx_cmd),
        .tx_data  (tx_data),
        .dn_req   (dn_req),
        .dn_cmd   (dn_cmd),
        .dn_data  (dn_data),
        .dn_ack   (dn_ack)
    );

    r2_up_path #(
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W)
    ) i_up (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (slow_en),
        .up_req   (up_req),
        .up_cmd   (up_cmd),
        .up_data  (up_data),
        .up_ack   (up_ack),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .rx_cmd   (rx_cmd),
        .rx_data  (rx_data)
    );

endmodule

// File: tb/test_ratio2_cmd_bridge.sv
module test_ratio2_cmd_bridge;

    localparam int CMD_W  = 8;
    localparam int DATA_W = 32;
    localparam int WORD_W = CMD_W + DATA_W;
    localparam int NB     = 8;
    localparam int NR     = 40;

    // {cmd[47:40], data[39:8], slow ack delay[7:4], rx stall cycles[3:0]}
    localparam logic [47:0] VEC [NB] = '{
        {8'h11, 32'h0000_0001, 4'd0, 4'd0},
        {8'h22, 32'hFFFF_FFFF, 4'd1, 4'd3},
        {8'h00, 32'h0000_0000, 4'd2, 4'd0},
        {8'hFF, 32'h8000_0000, 4'd0, 4'd5},
        {8'h5A, 32'hDEAD_BEEF, 4'd3, 4'd1},
        {8'hA5, 32'h0F0F_0F0F, 4'd0, 4'd2},
        {8'h3C, 32'h1357_9BDF, 4'd4, 4'd0},
        {8'hC3, 32'h2468_ACE0, 4'd1, 4'd7}
    };

    logic [1:0] tick = 2'd0;
    logic clk_f, clk_s;
    assign clk_f = ~tick[0];
    assign clk_s = tick[1];
    initial forever #4 tick = tick + 2'd1;

    logic rst_n, tx_valid, tx_ready, dn_req, dn_ack, up_req, up_ack, rx_valid, rx_rdy;
    logic [CMD_W-1:0]  tx_cmd, dn_cmd, up_cmd, rx_cmd, d_up_cmd;
    logic [DATA_W-1:0] tx_data, dn_data, up_data, rx_data, d_up_data;
    logic d_ack, d_up_req, m_ack, m_up_req, model_on, rnd_mode, done;
    logic [WORD_W-1:0] m_up_word;
    logic [WORD_W-1:0] dn_log [64];
    logic [WORD_W-1:0] up_src [64];
    int dn_got, up_idx, up_total, ack_dly, ack_wait, rx_cnt, n_chk, n_err;

    assign dn_ack = model_on ? m_ack : d_ack;
    assign up_req = model_on ? m_up_req : d_up_req;
    assign {up_cmd, up_data} = model_on ? m_up_word : {d_up_cmd, d_up_data};

    ratio2_cmd_bridge #(.CMD_W(CMD_W), .DATA_W(DATA_W), .LEAD_EN(1'b1)) i_ratio2_cmd_bridge (
        .clk(clk_f), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_cmd(tx_cmd), .tx_data(tx_data),
        .dn_req(dn_req), .dn_cmd(dn_cmd), .dn_data(dn_data), .dn_ack(dn_ack),
        .up_req(up_req), .up_cmd(up_cmd), .up_data(up_data), .up_ack(up_ack),
        .rx_valid(rx_valid), .rx_ready(rx_rdy), .rx_cmd(rx_cmd), .rx_data(rx_data)
    );

    // slow-domain partner, clocked by the half-rate clock
    always @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) begin
            m_ack <= 1'b0; m_up_req <= 1'b0; m_up_word <= '0;
            dn_got <= 0; up_idx <= 0; ack_wait <= 0;
        end else if (model_on) begin
            if (dn_req && !m_ack) begin
                if (ack_wait >= ack_dly || (rnd_mode && $urandom_range(0, 1) == 1)) begin
                    dn_log[dn_got] <= {dn_cmd, dn_data};
                    dn_got   <= dn_got + 1;
                    m_ack    <= 1'b1;
                    ack_wait <= 0;
                end else begin
                    ack_wait <= ack_wait + 1;
                end
            end else begin
                m_ack <= 1'b0;
            end
            if (m_up_req) begin
                if (up_ack) begin
                    m_up_req <= 1'b0;
                    up_idx   <= up_idx + 1;
                end
            end else if (up_idx < up_total && (!rnd_mode || $urandom_range(0, 1) == 1)) begin
                m_up_req  <= 1'b1;
                m_up_word <= up_src[up_idx];
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_f);
        #1;
    endtask

    task automatic send_tx(input logic [WORD_W-1:0] w);
        tx_valid = 1'b1;
        {tx_cmd, tx_data} = w;
        for (int g = 0; g < 400; g++) begin
            if (tx_ready) begin
                step();
                break;
            end
            step();
        end
        tx_valid = 1'b0;
    endtask

    function automatic logic [WORD_W-1:0] in_of(input logic [47:0] v);
        return {~v[47:40], v[39:8] ^ 32'h5A5A_0F0F};
    endfunction

    function automatic logic [WORD_W-1:0] rnd_word(input int k, input bit up);
        logic [CMD_W-1:0]  c;
        logic [DATA_W-1:0] d;
        c = 8'(k * 7 + 3 + (up ? 100 : 0));
        d = (32'(k) * 32'h9E37_79B9) ^ (up ? 32'hFFFF_0000 : 32'h0);
        return {c, d};
    endfunction

    initial begin
        repeat (30000) @(posedge clk_f);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        done = 0; n_chk = 0; n_err = 0; rx_cnt = 0;
        rst_n = 0; tx_valid = 0; tx_cmd = '0; tx_data = '0; rx_rdy = 0;
        d_ack = 0; d_up_req = 0; d_up_cmd = '0; d_up_data = '0;
        model_on = 0; rnd_mode = 0; up_total = 0; ack_dly = 0;

        repeat (3) @(posedge clk_f);
        #1;
        chk("R1 dn_req in reset", dn_req, 0);
        chk("R1 up_ack in reset", up_ack, 0);
        chk("R1 rx_valid in reset", rx_valid, 0);
        @(posedge clk_s);
        @(negedge clk_f);
        @(negedge clk_f);
        rst_n = 1;
        #1;
        // current cycle enabled (ends on a rising slow edge)
        chk("R2 ready in first enabled cycle", tx_ready, 1);
        step();
        chk("R2 ready low in disabled cycle", tx_ready, 0);

        // outbound directed: cur disabled
        step();
        tx_valid = 1; {tx_cmd, tx_data} = {8'hA5, 32'h1234_5678};
        step();
        chk("R4 dn_req after take", dn_req, 1);
        chk("R4 dn word after take", {dn_cmd, dn_data}, {8'hA5, 32'h1234_5678});
        tx_valid = 0;
        d_ack = 1;                     // disabled cycle only
        step();
        d_ack = 0;
        chk("R5 ready low while busy", tx_ready, 0);
        chk("R6 req kept after disabled ack", dn_req, 1);
        step();
        chk("R6 req still kept", dn_req, 1);
        step();
        d_ack = 1;                     // enabled cycle
        chk("R5 req kept until ack edge", dn_req, 1);
        step();
        d_ack = 0;
        chk("R5 req dropped after enabled ack", dn_req, 0);

        // cur disabled: valid offered in a disabled cycle
        tx_valid = 1; {tx_cmd, tx_data} = {8'h3C, 32'hCAFE_0001};
        step();
        chk("R2 no take in disabled cycle", dn_req, 0);
        chk("R2 ready in enabled idle cycle", tx_ready, 1);
        step();
        tx_valid = 0;
        chk("R4 word B launched", {dn_req, dn_cmd, dn_data}, {1'b1, 8'h3C, 32'hCAFE_0001});
        step();
        chk("R3 word B held second cycle", {dn_req, dn_cmd, dn_data}, {1'b1, 8'h3C, 32'hCAFE_0001});
        d_ack = 1;
        step();
        d_ack = 0;
        chk("R5 req dropped for B", dn_req, 0);

        // inbound directed: move to enabled
        step();
        d_up_req = 1; {d_up_cmd, d_up_data} = {8'h71, 32'h0000_AAAA};
        step();
        chk("R7 ack after capture", up_ack, 1);
        chk("R7 rx word W1", {rx_valid, rx_cmd, rx_data}, {1'b1, 8'h71, 32'h0000_AAAA});
        rx_rdy = 1;
        step();
        rx_rdy = 0;
        chk("R9 rx_valid clears after take", rx_valid, 0);
        chk("R7 ack second fast cycle", up_ack, 1);
        step();
        chk("R8 no duplicate capture of W1", rx_valid, 0);
        chk("R7 ack gone after two cycles", up_ack, 0);

        d_up_cmd = 8'h72; d_up_data = 32'h0000_BBBB;
        step();
        step();
        chk("R7 W2 captured", {up_ack, rx_valid, rx_cmd, rx_data}, {2'b11, 8'h72, 32'h0000_BBBB});
        d_up_cmd = 8'h73; d_up_data = 32'h0000_CCCC;
        step();
        step();
        chk("R7 ack cleared for W2", up_ack, 0);
        step();
        step();
        chk("R10 no ack while full", up_ack, 0);
        chk("R9 W2 held while full", {rx_valid, rx_cmd, rx_data}, {1'b1, 8'h72, 32'h0000_BBBB});
        rx_rdy = 1;
        step();
        rx_rdy = 0;
        chk("R9 W2 taken", rx_valid, 0);
        step();
        chk("R10 W3 taken after space", {up_ack, rx_cmd, rx_data}, {1'b1, 8'h73, 32'h0000_CCCC});
        d_up_req = 0;

        step();
        step();
        rx_rdy = 1;
        step();
        rx_rdy = 0;
        step();
        d_up_req = 1; {d_up_cmd, d_up_data} = {8'h74, 32'h0000_DDDD};
        step();
        d_up_req = 0;
        chk("R11 no ack for disabled-only req", up_ack, 0);
        chk("R11 no capture for disabled-only req", rx_valid, 0);
        step();
        chk("R11 still nothing captured", {up_ack, rx_valid}, 2'b00);

        // table-driven traffic with the slow partner
        model_on = 1;
        for (int i = 0; i < NB; i++) begin
            ack_dly = int'(VEC[i][7:4]);
            up_src[i] = in_of(VEC[i]);
            up_total = i + 1;
            send_tx(VEC[i][47:8]);
            for (int g = 0; g < 200 && dn_got <= i; g++) step();
            chk("R4 table outbound word", dn_log[i], VEC[i][47:8]);
            for (int g = 0; g < 200 && !rx_valid; g++) step();
            repeat (int'(VEC[i][3:0])) step();
            chk("R9 table rx held under stall", rx_valid, 1);
            chk("R7 table inbound word", {rx_cmd, rx_data}, up_src[i]);
            rx_rdy = 1;
            step();
            rx_rdy = 0;
        end
        repeat (30) step();
        chk("R8 no duplicate after table", rx_valid, 0);
        chk("R12 table outbound count", dn_got, NB);

        // random back-pressure, both directions concurrently
        rnd_mode = 1;
        ack_dly = 3;
        for (int k = 0; k < NR; k++) up_src[NB + k] = rnd_word(k, 1'b1);
        up_total = NB + NR;
        fork
            begin
                for (int k = 0; k < NR; k++) begin
                    send_tx(rnd_word(k, 1'b0));
                    repeat ($urandom_range(0, 2)) step();
                end
            end
            begin
                while (rx_cnt < NR) begin
                    rx_rdy = ($urandom_range(0, 2) != 0);
                    if (rx_valid && rx_rdy) begin
                        chk("R12 inbound order", {rx_cmd, rx_data}, up_src[NB + rx_cnt]);
                        rx_cnt++;
                    end
                    step();
                end
                rx_rdy = 0;
            end
        join
        repeat (40) step();
        chk("R12 outbound total", dn_got, NB + NR);
        for (int k = 0; k < NR; k++) chk("R12 outbound order", dn_log[NB + k], rnd_word(k, 1'b0));
        chk("R12 no extra inbound", rx_valid, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule